// File: doc/BRIEF.md
# Serial Port Register Bank

This block is the software-facing register file of a serial port that has a receive FIFO. It sits on a simple single-cycle read/write bus and decodes a 40-byte window. The window holds the mode, bit-rate, control, FIFO-control and port settings, a status register whose flags software clears by writing zeros, and windows onto the transmit data path and the receive FIFO. The settings go out on plain configuration ports. The serializer, baud generator and FIFO logic sit next to the block and use those ports.

Transmit bytes written by software go to the serializer with a one-cycle valid pulse. A read of the receive data location pops the FIFO. Break detection, receive-threshold detection and data-ready detection happen outside the block. Each of them reaches the status register as a one-cycle set pulse. Control bits drive the transmit and receive interrupt lines directly. A status read while the transmitter is enabled sets the two transmit-empty flags again.

Top module: `uart_regbank`

## Requirements
- R1: After reset, mode reads 0x00, control reads 0x20, FIFO control reads 0x0000, port reads 0x00, status reads 0x60, the bit-rate output is 0xFF, and both interrupt lines are low.
- R2: Writes are masked as follows: mode at offset 0x00 keeps bits 0x7B, control at 0x08 keeps bits 0xFA and port at 0x20 keeps bits 0xF3. Bit rate at 0x04 keeps all 8 bits and FIFO control at 0x18 keeps all 16 bits. Each stored value appears on its configuration output.
- R3: A read strobe returns its value on the read data bus in the next cycle. Mode, control, FIFO control and port read back what was stored. Bit rate (0x04) and transmit data (0x0C) read as 0.
- R4: The status register at 0x10 holds transmit-end (bit 6), transmit-empty (bit 5), break (bit 4), receive-threshold (bit 1) and data-ready (bit 0). Writing 0 to a bit clears its flag, writing 1 leaves the flag unchanged, and all other bits read 0.
- R5: A status write with 0 in bit 1 or in bit 0 drops the receive interrupt.
- R6: Writing offset 0x0C clears transmit-empty and presents the low byte on the transmit byte output with a valid pulse one cycle wide.
- R7: A control write with bit 5 at 0 sets transmit-end. Bit 7 of every control write becomes the transmit interrupt level. A control write with bit 6 at 0 drops the receive interrupt.
- R8: When control bit 5 is set, a status read returns the flags as they stood before the read, then sets transmit-empty and transmit-end.
- R9: A read of 0x14 returns the FIFO head byte. It pulses the pop output in the strobe cycle only when the FIFO count is nonzero. With an empty FIFO it returns 0 and does not pop.
- R10: A read of 0x1C returns the FIFO count. Reads of 0x24 and of unmapped offsets return 0. Writes to 0x14, 0x1C, 0x24 and unmapped offsets change no register.
- R11: Set pulses for break, receive-threshold and data-ready set their status flags. A receive-threshold pulse raises the receive interrupt only while control bit 6 is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busWr | input | 1 | Write strobe |
| busRd | input | 1 | Read strobe |
| busAddr | input | 6 | Byte offset in the window |
| busWrData | input | 16 | Write data |
| busRdData | output | 16 | Read data, valid the cycle after busRd |
| txByte | output | 8 | Byte for the serializer |
| txValid | output | 1 | One-cycle pulse with a new txByte |
| rxHead | input | 8 | Byte at the head of the receive FIFO |
| rxCount | input | 5 | Number of bytes in the receive FIFO |
| rxPop | output | 1 | Pop request to the receive FIFO |
| brkSet | input | 1 | Break detected pulse |
| rdfSet | input | 1 | Receive threshold or timeout pulse |
| drSet | input | 1 | Data-ready pulse |
| modeCfg | output | 8 | Stored mode value |
| rateCfg | output | 8 | Stored bit-rate value |
| ctrlCfg | output | 8 | Stored control value |
| fifoCfg | output | 16 | Stored FIFO control value |
| portCfg | output | 8 | Stored port value |
| txIrq | output | 1 | Transmit interrupt |
| rxIrq | output | 1 | Receive interrupt |

## Verification
The bench builds the block with its default 16-entry FIFO, so the count port is 5 bits wide. The bench can drive any count from empty to full. This covers the empty-FIFO read, where no pop may occur, and reads of counts above one nibble. The 6-bit address reaches offsets beyond the 0x24 line-status location, so the bench exercises writes and reads to unmapped offsets.

// File: rtl/uart_regbank_pkg.sv
package uart_regbank_pkg;

  localparam logic [5:0] OFS_MODE   = 6'h00;
  localparam logic [5:0] OFS_RATE   = 6'h04;
  localparam logic [5:0] OFS_CTRL   = 6'h08;
  localparam logic [5:0] OFS_TXDATA = 6'h0C;
  localparam logic [5:0] OFS_STAT   = 6'h10;
  localparam logic [5:0] OFS_RXDATA = 6'h14;
  localparam logic [5:0] OFS_FIFO   = 6'h18;
  localparam logic [5:0] OFS_COUNT  = 6'h1C;
  localparam logic [5:0] OFS_PORT   = 6'h20;
  localparam logic [5:0] OFS_LINE   = 6'h24;

  localparam logic [7:0] MODE_KEEP = 8'h7B;
  localparam logic [7:0] CTRL_KEEP = 8'hFA;
  localparam logic [7:0] PORT_KEEP = 8'hF3;

  // status and control bit positions
  localparam int ST_TEND = 6;
  localparam int ST_TDE  = 5;
  localparam int ST_BRK  = 4;
  localparam int ST_RDF  = 1;
  localparam int ST_DR   = 0;
  localparam int CT_TIE  = 7;
  localparam int CT_RIE  = 6;
  localparam int CT_TE   = 5;

  typedef enum logic [2:0] {
    SEL_ZERO, SEL_MODE, SEL_CTRL, SEL_STAT,
    SEL_RXDATA, SEL_FIFO, SEL_COUNT, SEL_PORT
  } rdSel_e;

  typedef struct packed {
    logic   wrMode;
    logic   wrRate;
    logic   wrCtrl;
    logic   wrTxData;
    logic   wrStat;
    logic   wrFifo;
    logic   wrPort;
    logic   rdStat;
    logic   rdStb;
    rdSel_e rdSel;
  } regStrobes_t;

endpackage

// File: rtl/uart_regbank_ctrl.sv
module uart_regbank_ctrl
  import uart_regbank_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int CNT_W  = 5
) (
  input  logic              busWr,
  input  logic              busRd,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [CNT_W-1:0]  rxCount,
  output regStrobes_t       strb,
  output logic              rxPop
);

  localparam logic [ADDR_W-1:0] A_MODE   = ADDR_W'(OFS_MODE);
  localparam logic [ADDR_W-1:0] A_RATE   = ADDR_W'(OFS_RATE);
  localparam logic [ADDR_W-1:0] A_CTRL   = ADDR_W'(OFS_CTRL);
  localparam logic [ADDR_W-1:0] A_TXDATA = ADDR_W'(OFS_TXDATA);
  localparam logic [ADDR_W-1:0] A_STAT   = ADDR_W'(OFS_STAT);
  localparam logic [ADDR_W-1:0] A_RXDATA = ADDR_W'(OFS_RXDATA);
  localparam logic [ADDR_W-1:0] A_FIFO   = ADDR_W'(OFS_FIFO);
  localparam logic [ADDR_W-1:0] A_COUNT  = ADDR_W'(OFS_COUNT);
  localparam logic [ADDR_W-1:0] A_PORT   = ADDR_W'(OFS_PORT);

  always_comb begin
    strb          = '0;
    strb.rdSel    = SEL_ZERO;
    strb.wrMode   = busWr && (busAddr == A_MODE);
    strb.wrRate   = busWr && (busAddr == A_RATE);
    strb.wrCtrl   = busWr && (busAddr == A_CTRL);
    strb.wrTxData = busWr && (busAddr == A_TXDATA);
    strb.wrStat   = busWr && (busAddr == A_STAT);
    strb.wrFifo   = busWr && (busAddr == A_FIFO);
    strb.wrPort   = busWr && (busAddr == A_PORT);
    strb.rdStb    = busRd;
    strb.rdStat   = busRd && (busAddr == A_STAT);
    if (busRd) begin
      unique case (busAddr)
        A_MODE:   strb.rdSel = SEL_MODE;
        A_CTRL:   strb.rdSel = SEL_CTRL;
        A_STAT:   strb.rdSel = SEL_STAT;
        A_RXDATA: strb.rdSel = (rxCount != '0) ? SEL_RXDATA : SEL_ZERO;
        A_FIFO:   strb.rdSel = SEL_FIFO;
        A_COUNT:  strb.rdSel = SEL_COUNT;
        A_PORT:   strb.rdSel = SEL_PORT;
        default:  strb.rdSel = SEL_ZERO;
      endcase
    end
  end

  assign rxPop = busRd && (busAddr == A_RXDATA) && (rxCount != '0);

endmodule

// File: rtl/uart_regbank_dp.sv
module uart_regbank_dp
  import uart_regbank_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int BYTE_W = 8,
  parameter int CNT_W  = 5
) (
  input  logic              clk,
  input  logic              rstN,
  input  regStrobes_t       strb,
  input  logic [DATA_W-1:0] wrData,
  input  logic [BYTE_W-1:0] rxHead,
  input  logic [CNT_W-1:0]  rxCount,
  input  logic              brkSet,
  input  logic              rdfSet,
  input  logic              drSet,
  output logic [DATA_W-1:0] rdData,
  output logic [BYTE_W-1:0] txByte,
  output logic              txValid,
  output logic [BYTE_W-1:0] modeReg,
  output logic [BYTE_W-1:0] rateReg,
  output logic [BYTE_W-1:0] ctrlReg,
  output logic [DATA_W-1:0] fifoReg,
  output logic [BYTE_W-1:0] portReg,
  output logic              txIrq,
  output logic              rxIrq
);

  localparam logic [BYTE_W-1:0] RATE_RST = '1;
  localparam logic [BYTE_W-1:0] CTRL_RST = BYTE_W'(1 << CT_TE);

  logic tendFlag, tdeFlag, brkFlag, rdfFlag, drFlag;
  logic [BYTE_W-1:0] wrByte;
  logic [BYTE_W-1:0] statByte;
  logic [DATA_W-1:0] rdMux;
  logic rearm;

  assign wrByte = wrData[BYTE_W-1:0];
  assign rearm  = strb.rdStat && ctrlReg[CT_TE];

  always_comb begin
    statByte          = '0;
    statByte[ST_TEND] = tendFlag;
    statByte[ST_TDE]  = tdeFlag;
    statByte[ST_BRK]  = brkFlag;
    statByte[ST_RDF]  = rdfFlag;
    statByte[ST_DR]   = drFlag;
  end

  always_comb begin
    unique case (strb.rdSel)
      SEL_MODE:   rdMux = DATA_W'(modeReg);
      SEL_CTRL:   rdMux = DATA_W'(ctrlReg);
      SEL_STAT:   rdMux = DATA_W'(statByte);
      SEL_RXDATA: rdMux = DATA_W'(rxHead);
      SEL_FIFO:   rdMux = fifoReg;
      SEL_COUNT:  rdMux = DATA_W'(rxCount);
      SEL_PORT:   rdMux = DATA_W'(portReg);
      default:    rdMux = '0;
    endcase
  end

  // configuration registers and read port
  always_ff @(posedge clk) begin
    if (!rstN) begin
      modeReg <= '0;
      rateReg <= RATE_RST;
      ctrlReg <= CTRL_RST;
      fifoReg <= '0;
      portReg <= '0;
      rdData  <= '0;
      txByte  <= '0;
      txValid <= 1'b0;
    end else begin
      txValid <= strb.wrTxData;
      if (strb.wrTxData) txByte  <= wrByte;
      if (strb.wrMode)   modeReg <= wrByte & MODE_KEEP;
      if (strb.wrRate)   rateReg <= wrByte;
      if (strb.wrCtrl)   ctrlReg <= wrByte & CTRL_KEEP;
      if (strb.wrFifo)   fifoReg <= wrData;
      if (strb.wrPort)   portReg <= wrByte & PORT_KEEP;
      if (strb.rdStb)    rdData  <= rdMux;
    end
  end

  // status flags: later assignments take priority
  always_ff @(posedge clk) begin
    if (!rstN) begin
      tendFlag <= 1'b1;
      tdeFlag  <= 1'b1;
      brkFlag  <= 1'b0;
      rdfFlag  <= 1'b0;
      drFlag   <= 1'b0;
    end else begin
      if (strb.wrStat && !wrData[ST_TEND]) tendFlag <= 1'b0;
      if (strb.wrCtrl && !wrData[CT_TE])   tendFlag <= 1'b1;
      if (rearm)                           tendFlag <= 1'b1;

      if (strb.wrStat && !wrData[ST_TDE])  tdeFlag <= 1'b0;
      if (strb.wrTxData)                   tdeFlag <= 1'b0;
      if (rearm)                           tdeFlag <= 1'b1;

      if (strb.wrStat && !wrData[ST_BRK])  brkFlag <= 1'b0;
      if (brkSet)                          brkFlag <= 1'b1;

      if (strb.wrStat && !wrData[ST_RDF])  rdfFlag <= 1'b0;
      if (rdfSet)                          rdfFlag <= 1'b1;

      if (strb.wrStat && !wrData[ST_DR])   drFlag <= 1'b0;
      if (drSet)                           drFlag <= 1'b1;
    end
  end

  // interrupt lines
  always_ff @(posedge clk) begin
    if (!rstN) begin
      txIrq <= 1'b0;
      rxIrq <= 1'b0;
    end else begin
      if (strb.wrCtrl) txIrq <= wrData[CT_TIE];
      if (strb.wrStat && (!wrData[ST_RDF] || !wrData[ST_DR])) rxIrq <= 1'b0;
      if (strb.wrCtrl && !wrData[CT_RIE]) rxIrq <= 1'b0;
      if (rdfSet && ctrlReg[CT_RIE]) rxIrq <= 1'b1;
    end
  end

  // R10
  wr_onehot_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strb.wrMode, strb.wrRate, strb.wrCtrl, strb.wrTxData,
              strb.wrStat, strb.wrFifo, strb.wrPort}));

  // R6
  tx_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.wrTxData |=> (txValid && !tdeFlag && txByte == $past(wrByte)));

  // R7
  tx_irq_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.wrCtrl |=> (txIrq == $past(wrData[CT_TIE])));

  // R7
  rx_irq_off_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strb.wrCtrl && !wrData[CT_RIE] && !rdfSet) |=> !rxIrq);

  // R8
  rearm_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strb.rdStat && ctrlReg[CT_TE]) |=> (tdeFlag && tendFlag));

  // R11
  rx_irq_on_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rdfSet && ctrlReg[CT_RIE]) |=> (rxIrq && rdfFlag));

endmodule

// File: rtl/uart_regbank.sv
module uart_regbank
  import uart_regbank_pkg::*;
#(
  parameter int ADDR_W     = 6,
  parameter int DATA_W     = 16,
  parameter int BYTE_W     = 8,
  parameter int FIFO_DEPTH = 16,
  localparam int CNT_W     = $clog2(FIFO_DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busWr,
  input  logic              busRd,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busWrData,
  output logic [DATA_W-1:0] busRdData,
  output logic [BYTE_W-1:0] txByte,
  output logic              txValid,
  input  logic [BYTE_W-1:0] rxHead,
  input  logic [CNT_W-1:0]  rxCount,
  output logic              rxPop,
  input  logic              brkSet,
  input  logic              rdfSet,
  input  logic              drSet,
  output logic [BYTE_W-1:0] modeCfg,
  output logic [BYTE_W-1:0] rateCfg,
  output logic [BYTE_W-1:0] ctrlCfg,
  output logic [DATA_W-1:0] fifoCfg,
  output logic [BYTE_W-1:0] portCfg,
  output logic              txIrq,
  output logic              rxIrq
);

  regStrobes_t strb;

  uart_regbank_ctrl #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) ctrl_i (
    .busWr(busWr), .busRd(busRd), .busAddr(busAddr),
    .rxCount(rxCount), .strb(strb), .rxPop(rxPop)
  );

  uart_regbank_dp #(.DATA_W(DATA_W), .BYTE_W(BYTE_W), .CNT_W(CNT_W)) dp_i (
    .clk(clk), .rstN(rstN), .strb(strb), .wrData(busWrData),
    .rxHead(rxHead), .rxCount(rxCount),
    .brkSet(brkSet), .rdfSet(rdfSet), .drSet(drSet),
    .rdData(busRdData), .txByte(txByte), .txValid(txValid),
    .modeReg(modeCfg), .rateReg(rateCfg), .ctrlReg(ctrlCfg),
    .fifoReg(fifoCfg), .portReg(portCfg),
    .txIrq(txIrq), .rxIrq(rxIrq)
  );

endmodule

// File: tb/uart_regbank_tb_top.sv
module uart_regbank_tb_top;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        busWr = 1'b0, busRd = 1'b0;
  logic [5:0]  busAddr = '0;
  logic [15:0] busWrData = '0;
  logic [15:0] busRdData;
  logic [7:0]  txByte;
  logic        txValid;
  logic [7:0]  rxHead = '0;
  logic [4:0]  rxCount = '0;
  logic        rxPop;
  logic        brkSet = 1'b0, rdfSet = 1'b0, drSet = 1'b0;
  logic [7:0]  modeCfg, rateCfg, ctrlCfg, portCfg;
  logic [15:0] fifoCfg;
  logic        txIrq, rxIrq;

  int checks = 0;
  int fails = 0;
  int popCnt = 0;
  logic [15:0] rv;

  always #10 clk = ~clk;

  uart_regbank dut_i (
    .clk(clk), .rstN(rstN), .busWr(busWr), .busRd(busRd), .busAddr(busAddr),
    .busWrData(busWrData), .busRdData(busRdData), .txByte(txByte),
    .txValid(txValid), .rxHead(rxHead), .rxCount(rxCount), .rxPop(rxPop),
    .brkSet(brkSet), .rdfSet(rdfSet), .drSet(drSet), .modeCfg(modeCfg),
    .rateCfg(rateCfg), .ctrlCfg(ctrlCfg), .fifoCfg(fifoCfg),
    .portCfg(portCfg), .txIrq(txIrq), .rxIrq(rxIrq)
  );

  always @(posedge clk) if (rstN && rxPop) popCnt <= popCnt + 1;

  // row: doWr, wrAddr, wrData, rdAddr, expected, requirement number
  localparam int NV = 11;
  localparam logic [48:0] VEC [NV] = '{
    {1'b1, 6'h00, 16'hFFFF, 6'h00, 16'h007B, 4'd2},   // R2 mode mask
    {1'b1, 6'h04, 16'h00A5, 6'h04, 16'h0000, 4'd3},   // R3 rate write-only
    {1'b1, 6'h20, 16'hFFFF, 6'h20, 16'h00F3, 4'd2},   // R2 port mask
    {1'b1, 6'h18, 16'hBEEF, 6'h18, 16'hBEEF, 4'd2},   // R2 fifo 16 bit
    {1'b1, 6'h08, 16'h00FF, 6'h08, 16'h00FA, 4'd2},   // R2 control mask
    {1'b1, 6'h08, 16'h0020, 6'h08, 16'h0020, 4'd3},   // R3 control readback
    {1'b1, 6'h24, 16'h0055, 6'h24, 16'h0000, 4'd10},  // R10 line status
    {1'b1, 6'h2C, 16'h1234, 6'h00, 16'h007B, 4'd10},  // R10 unmapped write
    {1'b1, 6'h1C, 16'h0077, 6'h1C, 16'h0000, 4'd10},  // R10 count write
    {1'b0, 6'h00, 16'h0000, 6'h0C, 16'h0000, 4'd3},   // R3 tx data reads 0
    {1'b1, 6'h00, 16'h0000, 6'h00, 16'h0000, 4'd3}    // R3 mode readback
  };

  task automatic check(input logic [15:0] act, input logic [15:0] exp,
                       input string req);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic busWrite(input logic [5:0] a, input logic [15:0] d);
    @(negedge clk);
    busWr = 1'b1; busAddr = a; busWrData = d;
    @(negedge clk);
    busWr = 1'b0;
  endtask

  task automatic busRead(input logic [5:0] a, output logic [15:0] d);
    @(negedge clk);
    busRd = 1'b1; busAddr = a;
    @(negedge clk);
    busRd = 1'b0;
    d = busRdData;
  endtask

  task automatic pulse(input int which);
    @(negedge clk);
    case (which)
      0: brkSet = 1'b1;
      1: rdfSet = 1'b1;
      default: drSet = 1'b1;
    endcase
    @(negedge clk);
    brkSet = 1'b0; rdfSet = 1'b0; drSet = 1'b0;
  endtask

  task automatic finishRun;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finishRun();
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R1 reset state
    @(negedge clk);
    check(16'(rateCfg), 16'h00FF, "R1 rate");
    check({14'd0, txIrq, rxIrq}, 16'h0000, "R1 irqs");
    busRead(6'h00, rv); check(rv, 16'h0000, "R1 mode");
    busRead(6'h08, rv); check(rv, 16'h0020, "R1 control");
    busRead(6'h18, rv); check(rv, 16'h0000, "R1 fifo");
    busRead(6'h20, rv); check(rv, 16'h0000, "R1 port");
    busRead(6'h10, rv); check(rv, 16'h0060, "R1 status");

    // register table
    for (int i = 0; i < NV; i++) begin
      if (VEC[i][48]) busWrite(VEC[i][47:42], VEC[i][41:26]);
      busRead(VEC[i][25:20], rv);
      check(rv, VEC[i][19:4], $sformatf("R%0d row %0d", VEC[i][3:0], i));
    end
    check(16'(rateCfg), 16'h00A5, "R2 rate output");
    check(fifoCfg, 16'hBEEF, "R2 fifo output");
    check(16'(portCfg), 16'h00F3, "R2 port output");

    // R6 transmit write, R8 rearm
    busWrite(6'h08, 16'h0000);
    @(negedge clk);
    busWr = 1'b1; busAddr = 6'h0C; busWrData = 16'h335A;
    @(negedge clk);
    busWr = 1'b0;
    check({7'd0, txValid, txByte}, 16'h015A, "R6 tx pulse");
    @(negedge clk);
    check({15'd0, txValid}, 16'h0000, "R6 pulse width");
    busRead(6'h10, rv); check(rv, 16'h0040, "R6 tde cleared");
    busRead(6'h10, rv); check(rv, 16'h0040, "R8 no rearm when disabled");
    busWrite(6'h08, 16'h0020);
    busRead(6'h10, rv); check(rv, 16'h0040, "R8 old value returned");
    busRead(6'h10, rv); check(rv, 16'h0060, "R8 rearmed");

    // R4 and R11 flags
    pulse(0); pulse(1); pulse(2);
    check({15'd0, rxIrq}, 16'h0000, "R11 no irq without enable");
    busRead(6'h10, rv); check(rv, 16'h0073, "R11 flags set");
    busWrite(6'h10, 16'h00FF);
    busRead(6'h10, rv); check(rv, 16'h0073, "R4 write ones keep");
    busWrite(6'h10, 16'h00EF);
    busRead(6'h10, rv); check(rv, 16'h0063, "R4 clear break");
    busWrite(6'h10, 16'h0000);
    busRead(6'h10, rv); check(rv, 16'h0000, "R4 clear all");
    busRead(6'h10, rv); check(rv, 16'h0060, "R8 rearm after clear");

    // R5, R7, R11 interrupts
    busWrite(6'h08, 16'h0060);
    pulse(1);
    check({15'd0, rxIrq}, 16'h0001, "R11 rx irq raised");
    busWrite(6'h10, 16'h00FE);
    check({15'd0, rxIrq}, 16'h0000, "R5 status write drops irq");
    pulse(1);
    check({15'd0, rxIrq}, 16'h0001, "R11 rx irq again");
    busWrite(6'h08, 16'h0020);
    check({15'd0, rxIrq}, 16'h0000, "R7 rie zero drops irq");
    busWrite(6'h08, 16'h00A0);
    check({15'd0, txIrq}, 16'h0001, "R7 tx irq high");
    busWrite(6'h08, 16'h0020);
    check({15'd0, txIrq}, 16'h0000, "R7 tx irq low");
    busWrite(6'h08, 16'h0000);
    busWrite(6'h10, 16'h00BF);
    busRead(6'h10, rv); check(rv & 16'h0040, 16'h0000, "R4 tend cleared");
    busWrite(6'h08, 16'h0000);
    busRead(6'h10, rv); check(rv & 16'h0040, 16'h0040, "R7 te zero sets tend");

    // R9 receive reads, R10 count
    rxCount = 5'd3; rxHead = 8'hC3;
    @(negedge clk);
    busRd = 1'b1; busAddr = 6'h14;
    #1 check({15'd0, rxPop}, 16'h0001, "R9 pop during strobe");
    @(negedge clk);
    busRd = 1'b0;
    check(busRdData, 16'h00C3, "R9 head byte");
    @(negedge clk);
    check(16'(popCnt), 16'd1, "R9 single pop");
    rxCount = 5'd0;
    busRead(6'h14, rv); check(rv, 16'h0000, "R9 empty read");
    check(16'(popCnt), 16'd1, "R9 no pop when empty");
    rxCount = 5'd16;
    busRead(6'h1C, rv); check(rv, 16'h0010, "R10 count read");
    busRead(6'h30, rv); check(rv, 16'h0000, "R10 unmapped read");

    finishRun();
  end

endmodule